// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps instructions that enter in program order but finish in any order, and retires them one at a time, oldest first. Each new instruction claims the next free slot. The slot number comes back as the instruction's destination tag. Other stages use that tag to rename registers and to match results on the shared result bus.

A finished result stays in its slot until the instruction becomes the oldest one held. Until then, younger instructions can read it through the operand lookup port. Registers and memory are changed only at retirement. At that point the oldest entry produces one of three things: a register write, a store request, or, for a branch, nothing.

A branch that was predicted wrongly, or an instruction that faulted, does nothing while it is young. When it becomes the oldest entry it raises a one-cycle flush with a redirect address, and the buffer discards every entry it still holds.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `commit_valid` and `flush` are 0.
- R2: Each accepted allocation returns the tag one above the previous tag, modulo ENTRIES, starting from 0. When ENTRIES entries are held and the oldest is not retiring, `alloc_ready` is 0.
- R3: A writeback stores `wb_data`, `wb_addr` and the two flags in the entry named by `wb_tag` and marks it done. The lookup port then reports `lookup_ready`=1 and the stored value. A writeback to a tag that holds no entry is ignored.
- R4: Only the oldest entry may retire, and only after it is done. A younger entry that is done waits, with `commit_valid` held at 0.
- R5: `alloc_kind` encodes 0 = register op, 1 = branch, 2 = store. On retirement, a register op asserts `commit_rf_we` with its `commit_dst` and `commit_data`. A store asserts `commit_st_req` with `commit_addr` and `commit_data`, and no register write. A correctly predicted branch asserts neither.
- R6: A retiring branch with `wb_mispred` set raises `flush` for that cycle, with `flush_pc` equal to its written-back data and no register write. In the next cycle the buffer is empty, and the next tag continues the sequence.
- R7: A retiring entry with `wb_exc` set raises `flush` with `flush_pc` equal to HANDLER_PC and makes neither a register write nor a store.
- R8: When the buffer is full and the oldest entry retires in the same cycle, `alloc_ready` is 1 and the allocation is accepted.
- R9: During a flush cycle `alloc_ready` is 0, and an allocation offered in that cycle is dropped without using a tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_kind | input | 2 | 0 register op, 1 branch, 2 store |
| alloc_dst | input | AW | Destination register |
| alloc_pc | input | PCW | Instruction address |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | log2(ENTRIES) | Tag given to the allocation |
| wb_valid | input | 1 | Result bus valid |
| wb_tag | input | log2(ENTRIES) | Result bus tag |
| wb_data | input | DW | Result, or branch target |
| wb_addr | input | DW | Store address |
| wb_exc | input | 1 | Instruction faulted |
| wb_mispred | input | 1 | Branch was mispredicted |
| lookup_tag | input | log2(ENTRIES) | Operand tag to read |
| lookup_ready | output | 1 | Tagged entry holds a result |
| lookup_data | output | DW | Held result |
| commit_valid | output | 1 | Oldest entry retires |
| commit_rf_we | output | 1 | Register write |
| commit_st_req | output | 1 | Store request |
| commit_dst | output | AW | Register written |
| commit_data | output | DW | Write or store data |
| commit_addr | output | DW | Store address |
| commit_pc | output | PCW | Address of retiring instruction |
| flush | output | 1 | Discard all entries |
| flush_pc | output | PCW | Redirect address |

## Verification
The assertions run on every cycle. They check that the occupancy tracked in the checker never allows an allocation into a full buffer and never allows a retirement from an empty one. They check that tags advance by one per accepted allocation, and that register write, store request and flush are mutually consistent. They also check that a flush blocks allocation and leaves the buffer empty on the next cycle.

Three things need the bench's scenarios, because they depend on which values went in. These are the strict program order of the retired data under out-of-order writeback, the correct choice of redirect address, and the fact that stray writebacks and discarded younger entries are never seen again.

// File: rtl/rob_core.sv
module rob_core #(
  parameter int ENTRIES = 16,
  parameter int DW = 32,
  parameter int AW = 5,
  parameter int PCW = 32,
  parameter logic [PCW-1:0] HANDLER_PC = 32'h0000_0100
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_valid,
  input  logic [1:0]                  alloc_kind,
  input  logic [AW-1:0]               alloc_dst,
  input  logic [PCW-1:0]              alloc_pc,
  output logic                        alloc_ready,
  output logic [$clog2(ENTRIES)-1:0]  alloc_tag,
  input  logic                        wb_valid,
  input  logic [$clog2(ENTRIES)-1:0]  wb_tag,
  input  logic [DW-1:0]               wb_data,
  input  logic [DW-1:0]               wb_addr,
  input  logic                        wb_exc,
  input  logic                        wb_mispred,
  input  logic [$clog2(ENTRIES)-1:0]  lookup_tag,
  output logic                        lookup_ready,
  output logic [DW-1:0]               lookup_data,
  output logic                        commit_valid,
  output logic                        commit_rf_we,
  output logic                        commit_st_req,
  output logic [AW-1:0]               commit_dst,
  output logic [DW-1:0]               commit_data,
  output logic [DW-1:0]               commit_addr,
  output logic [PCW-1:0]              commit_pc,
  output logic                        flush,
  output logic [PCW-1:0]              flush_pc
);
  localparam int IW = $clog2(ENTRIES);
  localparam logic [1:0] K_REG = 2'd0;
  localparam logic [1:0] K_BR  = 2'd1;
  localparam logic [1:0] K_ST  = 2'd2;

  logic [AW-1:0]  e_dst  [ENTRIES];
  logic [DW-1:0]  e_data [ENTRIES];
  logic [DW-1:0]  e_addr [ENTRIES];
  logic [PCW-1:0] e_pc   [ENTRIES];
  logic [1:0]     e_kind [ENTRIES];
  logic [ENTRIES-1:0] e_vld, e_rdy, e_exc, e_mis;

  logic [IW:0] head, tail;
  logic [IW-1:0] hidx, tidx;
  logic empty, full, head_go, alloc_fire, h_exc, h_mis;

  assign hidx  = head[IW-1:0];
  assign tidx  = tail[IW-1:0];
  assign empty = head == tail;
  assign full  = (head[IW] != tail[IW]) && (hidx == tidx);

  assign head_go = !empty && e_rdy[hidx];
  assign h_exc   = e_exc[hidx];
  assign h_mis   = (e_kind[hidx] == K_BR) && e_mis[hidx];

  assign flush    = head_go && (h_exc || h_mis);
  assign flush_pc = h_exc ? HANDLER_PC : PCW'(e_data[hidx]);

  assign commit_valid  = head_go;
  assign commit_rf_we  = head_go && !h_exc && (e_kind[hidx] == K_REG);
  assign commit_st_req = head_go && !h_exc && (e_kind[hidx] == K_ST);
  assign commit_dst    = e_dst[hidx];
  assign commit_data   = e_data[hidx];
  assign commit_addr   = e_addr[hidx];
  assign commit_pc     = e_pc[hidx];

  assign alloc_ready = (!full || head_go) && !flush;
  assign alloc_tag   = tidx;
  assign alloc_fire  = alloc_valid && alloc_ready;

  assign lookup_ready = e_vld[lookup_tag] && e_rdy[lookup_tag];
  assign lookup_data  = e_data[lookup_tag];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      e_vld <= '0;
      e_rdy <= '0;
    end else if (flush) begin
      head  <= tail;
      e_vld <= '0;
      e_rdy <= '0;
    end else begin
      if (head_go) begin
        e_vld[hidx] <= 1'b0;
        e_rdy[hidx] <= 1'b0;
        head <= head + 1'b1;
      end
      if (wb_valid && e_vld[wb_tag])
        e_rdy[wb_tag] <= 1'b1;
      if (alloc_fire) begin
        e_vld[tidx] <= 1'b1;
        e_rdy[tidx] <= 1'b0;
        tail <= tail + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wb_valid && e_vld[wb_tag]) begin
      e_data[wb_tag] <= wb_data;
      e_addr[wb_tag] <= wb_addr;
      e_exc[wb_tag]  <= wb_exc;
      e_mis[wb_tag]  <= wb_mispred;
    end
    if (alloc_fire) begin
      e_dst[tidx]  <= alloc_dst;
      e_pc[tidx]   <= alloc_pc;
      e_kind[tidx] <= alloc_kind;
      e_exc[tidx]  <= 1'b0;
      e_mis[tidx]  <= 1'b0;
    end
  end
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int ENTRIES = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       alloc_valid,
  input logic                       alloc_ready,
  input logic [$clog2(ENTRIES)-1:0] alloc_tag,
  input logic                       commit_valid,
  input logic                       commit_rf_we,
  input logic                       commit_st_req,
  input logic                       flush
);
  localparam int IW = $clog2(ENTRIES);
  logic [IW:0] occ;
  logic fire;
  assign fire = alloc_valid && alloc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else if (flush) occ <= '0;
    else occ <= occ + (IW+1)'(fire) - (IW+1)'(commit_valid);
  end

  a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (IW+1)'(ENTRIES));
  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == (IW+1)'(ENTRIES)) && !commit_valid |-> !alloc_ready);
  a_r2_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> alloc_tag == IW'($past(alloc_tag) + 1'b1));
  a_r4_no_empty_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> occ != '0);
  a_r5_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_rf_we && commit_st_req));
  a_r5_action_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_rf_we || commit_st_req || flush) |-> commit_valid);
  a_r7_flush_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !commit_rf_we && !commit_st_req);
  a_r9_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !alloc_ready);
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !commit_valid && alloc_ready);
endmodule

bind rob_core rob_core_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_tag(alloc_tag), .commit_valid(commit_valid), .commit_rf_we(commit_rf_we),
  .commit_st_req(commit_st_req), .flush(flush)
);

// File: tb/rob_core_tb.sv
module rob_core_tb;
  localparam int N = 16;
  localparam int IW = 4;
  localparam logic [31:0] HPC = 32'h0000_0100;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0;
  logic [1:0] alloc_kind = 0;
  logic [4:0] alloc_dst = 0;
  logic [31:0] alloc_pc = 0;
  logic alloc_ready;
  logic [IW-1:0] alloc_tag;
  logic wb_valid = 0, wb_exc = 0, wb_mispred = 0;
  logic [IW-1:0] wb_tag = 0, lookup_tag = 0;
  logic [31:0] wb_data = 0, wb_addr = 0;
  logic lookup_ready;
  logic [31:0] lookup_data;
  logic commit_valid, commit_rf_we, commit_st_req, flush;
  logic [4:0] commit_dst;
  logic [31:0] commit_data, commit_addr, commit_pc, flush_pc;

  int checks = 0, fails = 0;
  bit done = 0;
  int exp_tag = 0;

  always #5 clk = ~clk;

  rob_core u_dut (.*);

  localparam logic [36:0] VEC [8] = '{
    {5'd1, 32'h1111_0001}, {5'd2, 32'h2222_0002}, {5'd3, 32'hdead_beef},
    {5'd31, 32'h0000_0000}, {5'd7, 32'hffff_ffff}, {5'd9, 32'h0bad_cafe},
    {5'd12, 32'h1234_5678}, {5'd0, 32'h8000_0001}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    alloc_valid = 0; wb_valid = 0; wb_exc = 0; wb_mispred = 0;
  endtask

  task automatic alloc(input logic [1:0] k, input logic [4:0] d, input logic [31:0] pc, output int tag);
    chk(alloc_ready, "R2 ready", 32'(alloc_ready), 1);
    chk(alloc_tag == IW'(exp_tag), "R2 tag", 32'(alloc_tag), 32'(exp_tag));
    tag = exp_tag;
    alloc_valid = 1; alloc_kind = k; alloc_dst = d; alloc_pc = pc;
    tick();
    exp_tag = (exp_tag + 1) % N;
  endtask

  task automatic wb(input int t, input logic [31:0] d, input logic [31:0] a, input bit e, input bit m);
    wb_valid = 1; wb_tag = IW'(t); wb_data = d; wb_addr = a; wb_exc = e; wb_mispred = m;
    tick();
  endtask

  initial begin
    int t, ta, tb, tc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(alloc_ready && !commit_valid && !flush && alloc_tag == 0, "R1 reset", {alloc_tag, 3'b0, flush, commit_valid, alloc_ready}, 32'h1);

    for (int i = 0; i < 8; i++) alloc(2'd0, VEC[i][36:32], 32'h1000 + 32'(4*i), t);
    for (int i = 7; i >= 1; i--) begin
      wb(i, VEC[i][31:0], 0, 0, 0);
      chk(!commit_valid, "R4 waits for head", 32'(commit_valid), 0);
    end
    lookup_tag = 5; #1;
    chk(lookup_ready && lookup_data == VEC[5][31:0], "R3 lookup", lookup_data, VEC[5][31:0]);
    lookup_tag = 0; #1;
    chk(!lookup_ready, "R3 lookup pending", 32'(lookup_ready), 0);
    wb(0, VEC[0][31:0], 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      chk(commit_valid && commit_rf_we && !commit_st_req, "R5 reg commit", {commit_st_req, commit_rf_we, commit_valid}, 3);
      chk(commit_dst == VEC[i][36:32] && commit_data == VEC[i][31:0], "R4 program order", commit_data, VEC[i][31:0]);
      tick();
    end
    chk(!commit_valid, "R4 drained", 32'(commit_valid), 0);

    wb(12, 32'h5555_5555, 0, 0, 0);
    lookup_tag = 12; #1;
    chk(!lookup_ready, "R3 stray writeback ignored", 32'(lookup_ready), 0);

    for (int i = 0; i < N; i++) alloc(2'd0, 5'd4, 32'h2000, t);
    chk(!alloc_ready, "R2 full", 32'(alloc_ready), 0);
    lookup_tag = 12; #1;
    chk(!lookup_ready, "R3 stray writeback ignored after alloc", 32'(lookup_ready), 0);
    wb(8, 32'h0000_0042, 0, 0, 0);
    chk(commit_valid && alloc_ready, "R8 full with retire", {commit_valid, alloc_ready}, 3);
    alloc(2'd0, 5'd6, 32'h3000, t);
    chk(!alloc_ready && !commit_valid, "R8 full again", {commit_valid, alloc_ready}, 0);

    wb(9, 32'h0, 0, 1, 0);
    chk(flush && flush_pc == HPC, "R7 exception redirect", flush_pc, HPC);
    chk(!commit_rf_we && !commit_st_req, "R7 no write", {commit_st_req, commit_rf_we}, 0);
    chk(!alloc_ready, "R9 blocked during flush", 32'(alloc_ready), 0);
    alloc_valid = 1; alloc_kind = 0;
    tick();
    chk(!commit_valid && alloc_ready && alloc_tag == IW'(exp_tag), "R9 dropped alloc", 32'(alloc_tag), 32'(exp_tag));

    alloc(2'd2, 5'd0, 32'h4000, ta);
    alloc(2'd1, 5'd0, 32'h4004, tb);
    alloc(2'd0, 5'd8, 32'h4008, tc);
    wb(tc, 32'h7777, 0, 0, 0);
    wb(ta, 32'hcafe_0001, 32'h0000_8000, 0, 0);
    chk(commit_st_req && !commit_rf_we && commit_addr == 32'h8000 && commit_data == 32'hcafe_0001, "R5 store", commit_addr, 32'h8000);
    chk(commit_pc == 32'h4000, "R5 store pc", commit_pc, 32'h4000);
    tick();
    chk(!commit_valid, "R4 branch pending", 32'(commit_valid), 0);
    wb(tb, 32'h0000_0400, 0, 0, 1);
    chk(commit_valid && flush && flush_pc == 32'h400, "R6 mispredict redirect", flush_pc, 32'h400);
    chk(!commit_rf_we, "R6 no write", 32'(commit_rf_we), 0);
    tick();
    lookup_tag = IW'(tc); #1;
    chk(!commit_valid && !lookup_ready && alloc_ready, "R6 younger discarded", {commit_valid, lookup_ready}, 0);

    alloc(2'd1, 5'd0, 32'h5000, t);
    wb(t, 32'h0000_0600, 0, 0, 0);
    chk(commit_valid && !flush && !commit_rf_we && !commit_st_req, "R5 correct branch", {flush, commit_st_req, commit_rf_we, commit_valid}, 1);
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule